// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory for a range of memory blocks in a distributed shared-memory system with a small, fixed number of processors. Each block has a directory entry and a data word in the local memory. The entry records whether no cache holds the block (Uncached), one or more caches hold clean copies (Shared), or exactly one cache holds a writable, possibly dirty copy (Exclusive). The entry also holds a presence vector with one bit per processor.

Caches send read misses and write misses on a request channel. Write-backs, both voluntary evictions and answers to a fetch, arrive on a separate write-back channel. The directory answers on a single outgoing message channel. Invalidations go only to the processors whose presence bits are set, and fetches go only to the recorded owner. Nothing is broadcast.

The controller serves one miss at a time. While a fetch answer is outstanding it holds off new misses. It keeps draining the write-back channel during that time, so an owner's unrelated eviction cannot block the answer it owes.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector. The memory word of block i is 0xC0DE0000 + i. No message is offered, and both input channels are ready.
- R2: A read miss to an Uncached block sends a reply carrying the memory word. The reply has message kind 0, and its destination mask has only bit p set for the requesting processor p. The block becomes Shared with the requester as its only sharer.
- R3: A write miss to an Uncached block sends a reply with the memory word. The block becomes Exclusive, owned by the requester.
- R4: A read miss to a Shared block replies with the memory word and adds the requester to the presence vector. The earlier sharers stay recorded.
- R5: A write miss to a Shared block that has other sharers first sends one invalidate. The invalidate has kind 1, its mask holds exactly the other sharers, and its data is zero. The reply to the requester follows, and the block becomes Exclusive to the requester.
- R6: A write miss to a Shared block whose only sharer is the requester sends the reply directly, with no invalidate.
- R7: A read miss to an Exclusive block sends a fetch (kind 2, data zero) to the owner alone. The data the owner writes back is stored in memory and forwarded in the reply. The block becomes Shared by the owner and the requester.
- R8: A write miss to an Exclusive block sends a fetch-and-invalidate (kind 3) to the owner. The returned data is stored and forwarded, and the block stays Exclusive with the requester as its only owner.
- R9: A write-back from the owner of an Exclusive block stores its data, clears the presence vector and makes the block Uncached. No message is sent.
- R10: A write-back for a block that the sender does not own in Exclusive is accepted and discarded. Memory and the directory entry are unchanged.
- R11: Once a miss is accepted, the request channel stays not-ready until that miss's reply is handed over. While a fetch answer is awaited, the write-back channel stays ready and evictions of other blocks take effect.
- R12: While a message is offered and not taken, its kind, mask, address and data are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Miss request accepted when high with req_valid |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_proc | input | PW | Requesting processor number |
| req_addr | input | AW | Block index |
| wb_valid | input | 1 | Write-back offered |
| wb_ready | output | 1 | Write-back accepted when high with wb_valid |
| wb_proc | input | PW | Processor sending the write-back |
| wb_addr | input | AW | Block index of the write-back |
| wb_data | input | DW | Block data |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Outgoing message taken |
| msg_kind | output | 2 | 0 reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dest | output | NPROC | Destination mask, bit i = processor i |
| msg_addr | output | AW | Block index |
| msg_data | output | DW | Reply data, zero for other kinds |

## Verification
The bench walks one block through every directory transition and checks the exact destination mask at each step. A presence vector that overwrote instead of adding, or that left the requester in the invalidate set, would show a wrong mask. A write by the sole sharer must produce no invalidate, and a design that always invalidated would emit a spurious message. Fetch answers must land in memory, so the bench reads the block back after its data has moved through a fetch. A design that forwarded the data but did not store it would return a stale word. Misplaced write-backs are checked as well: a foreign or stale write-back must leave the owner recorded, and an eviction of another block arriving during a fetch wait must take effect without deadlock.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    MSG_REPLY     = 2'd0,
    MSG_INVAL     = 2'd1,
    MSG_FETCH     = 2'd2,
    MSG_FETCH_INV = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INV   = 3'd1,
    ST_FETCH = 3'd2,
    ST_WAIT  = 3'd3,
    ST_REPLY = 3'd4
  } ctl_state_e;

  // Power-on content of a memory word, derived from the block index.
  function automatic logic [31:0] seed_word(input int unsigned idx);
    return 32'hC0DE_0000 | (idx & 32'h0000_FFFF);
  endfunction

endpackage

// File: rtl/hdc_entry_table.sv
module hdc_entry_table
  import hdc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_a_idx,
  output blk_state_e       rd_a_state,
  output logic [NPROC-1:0] rd_a_sharers,
  input  logic [AW-1:0]    rd_b_idx,
  output blk_state_e       rd_b_state,
  output logic [NPROC-1:0] rd_b_sharers,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  blk_state_e       wr_state,
  input  logic [NPROC-1:0] wr_sharers
);

  blk_state_e       st_all [NBLK];
  logic [NPROC-1:0] sh_all [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_entry
    blk_state_e       st_r;
    logic [NPROC-1:0] sh_r;
    logic             hit;

    assign hit = wr_en && (wr_idx == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r <= BLK_UNC;
        sh_r <= '0;
      end else if (hit) begin
        st_r <= wr_state;
        sh_r <= wr_sharers;
      end
    end

    assign st_all[g] = st_r;
    assign sh_all[g] = sh_r;
  end

  assign rd_a_state   = st_all[rd_a_idx];
  assign rd_a_sharers = sh_all[rd_a_idx];
  assign rd_b_state   = st_all[rd_b_idx];
  assign rd_b_sharers = sh_all[rd_b_idx];

endmodule

// File: rtl/hdc_block_mem.sv
module hdc_block_mem
  import hdc_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int AW   = 3,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] word_all [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_word
    logic [DW-1:0] word_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_r <= DW'(seed_word(g));
      end else if (wr_en && (wr_idx == AW'(g))) begin
        word_r <= wr_data;
      end
    end

    assign word_all[g] = word_r;
  end

  assign rd_data = word_all[rd_idx];

endmodule

// File: rtl/hdc_plan.sv
// Directory transition for one miss: next entry, invalidate set, fetch need.
module hdc_plan
  import hdc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int PW    = 2
) (
  input  blk_state_e       cur_state,
  input  logic [NPROC-1:0] cur_sharers,
  input  logic             is_write,
  input  logic [PW-1:0]    proc,
  output blk_state_e       nxt_state,
  output logic [NPROC-1:0] nxt_sharers,
  output logic [NPROC-1:0] inv_mask,
  output logic             need_fetch
);

  localparam logic [NPROC-1:0] ONE = NPROC'(1);

  logic [NPROC-1:0] pbit;
  assign pbit = ONE << proc;

  always_comb begin
    nxt_state   = cur_state;
    nxt_sharers = cur_sharers;
    inv_mask    = '0;
    need_fetch  = 1'b0;
    case (cur_state)
      BLK_SHR: begin
        if (is_write) begin
          inv_mask    = cur_sharers & ~pbit;
          nxt_state   = BLK_EXC;
          nxt_sharers = pbit;
        end else begin
          nxt_sharers = cur_sharers | pbit;
        end
      end
      BLK_EXC: begin
        need_fetch = 1'b1;
        if (is_write) begin
          nxt_state   = BLK_EXC;
          nxt_sharers = pbit;
        end else begin
          nxt_state   = BLK_SHR;
          nxt_sharers = cur_sharers | pbit;
        end
      end
      default: begin
        nxt_state   = is_write ? BLK_EXC : BLK_SHR;
        nxt_sharers = pbit;
      end
    endcase
  end

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hdc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 32,
  parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
  parameter int AW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [PW-1:0]    req_proc,
  input  logic [AW-1:0]    req_addr,
  input  logic             wb_valid,
  output logic             wb_ready,
  input  logic [PW-1:0]    wb_proc,
  input  logic [AW-1:0]    wb_addr,
  input  logic [DW-1:0]    wb_data,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [1:0]       msg_kind,
  output logic [NPROC-1:0] msg_dest,
  output logic [AW-1:0]    msg_addr,
  output logic [DW-1:0]    msg_data
);

  function automatic logic [NPROC-1:0] proc_onehot(input logic [PW-1:0] p);
    logic [NPROC-1:0] m;
    m = '0;
    m[p] = 1'b1;
    return m;
  endfunction

  ctl_state_e       st_q;
  logic [PW-1:0]    pend_proc;
  logic [AW-1:0]    pend_addr;
  logic             pend_write;
  logic [NPROC-1:0] dest_q;
  logic [DW-1:0]    hold_q;

  // Named events for the checker
  logic in_idle, in_wait;
  logic req_fire, wb_fire;
  logic wb_from_owner, wb_is_answer;
  logic ev_wb_commit, ev_fetch_done, ev_req_direct;

  // Table and plan wiring
  logic [AW-1:0]    tab_a_idx;
  blk_state_e       a_state, b_state;
  logic [NPROC-1:0] a_sh, b_sh;
  logic             plan_write;
  logic [PW-1:0]    plan_proc;
  blk_state_e       nxt_state;
  logic [NPROC-1:0] nxt_sh, inv_mask;
  logic             need_fetch;
  logic             tab_we;
  logic [AW-1:0]    tab_widx;
  blk_state_e       tab_wstate;
  logic [NPROC-1:0] tab_wsh;
  logic [DW-1:0]    mem_rd;

  assign in_idle   = (st_q == ST_IDLE);
  assign in_wait   = (st_q == ST_WAIT);
  assign req_ready = in_idle && !wb_valid;
  assign wb_ready  = in_idle || in_wait;
  assign req_fire  = req_valid && req_ready;
  assign wb_fire   = wb_valid && wb_ready;

  assign tab_a_idx  = in_idle ? req_addr  : pend_addr;
  assign plan_write = in_idle ? req_write : pend_write;
  assign plan_proc  = in_idle ? req_proc  : pend_proc;

  hdc_entry_table #(.NPROC(NPROC), .NBLK(NBLK), .AW(AW)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_a_idx     (tab_a_idx),
    .rd_a_state   (a_state),
    .rd_a_sharers (a_sh),
    .rd_b_idx     (wb_addr),
    .rd_b_state   (b_state),
    .rd_b_sharers (b_sh),
    .wr_en        (tab_we),
    .wr_idx       (tab_widx),
    .wr_state     (tab_wstate),
    .wr_sharers   (tab_wsh)
  );

  hdc_plan #(.NPROC(NPROC), .PW(PW)) u_plan (
    .cur_state   (a_state),
    .cur_sharers (a_sh),
    .is_write    (plan_write),
    .proc        (plan_proc),
    .nxt_state   (nxt_state),
    .nxt_sharers (nxt_sh),
    .inv_mask    (inv_mask),
    .need_fetch  (need_fetch)
  );

  // Only the recorded owner of an Exclusive block may change memory.
  assign wb_from_owner = (b_state == BLK_EXC) && b_sh[wb_proc];
  assign wb_is_answer  = in_wait && (wb_addr == pend_addr) && wb_from_owner;
  assign ev_wb_commit  = wb_fire && wb_from_owner;
  assign ev_fetch_done = wb_fire && wb_is_answer;
  assign ev_req_direct = req_fire && !need_fetch;

  always_comb begin
    tab_we     = 1'b0;
    tab_widx   = req_addr;
    tab_wstate = nxt_state;
    tab_wsh    = nxt_sh;
    if (ev_fetch_done) begin
      tab_we   = 1'b1;
      tab_widx = pend_addr;
    end else if (ev_wb_commit) begin
      tab_we     = 1'b1;
      tab_widx   = wb_addr;
      tab_wstate = BLK_UNC;
      tab_wsh    = '0;
    end else if (ev_req_direct) begin
      tab_we = 1'b1;
    end
  end

  hdc_block_mem #(.NBLK(NBLK), .AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (req_addr),
    .rd_data (mem_rd),
    .wr_en   (ev_wb_commit),
    .wr_idx  (wb_addr),
    .wr_data (wb_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pend_proc  <= '0;
      pend_addr  <= '0;
      pend_write <= 1'b0;
      dest_q     <= '0;
      hold_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_fire) begin
            pend_proc  <= req_proc;
            pend_addr  <= req_addr;
            pend_write <= req_write;
            if (need_fetch) begin
              dest_q <= a_sh;
              st_q   <= ST_FETCH;
            end else if (inv_mask != '0) begin
              dest_q <= inv_mask;
              hold_q <= mem_rd;
              st_q   <= ST_INV;
            end else begin
              dest_q <= proc_onehot(req_proc);
              hold_q <= mem_rd;
              st_q   <= ST_REPLY;
            end
          end
        end
        ST_INV: begin
          if (msg_ready) begin
            dest_q <= proc_onehot(pend_proc);
            st_q   <= ST_REPLY;
          end
        end
        ST_FETCH: begin
          if (msg_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ev_fetch_done) begin
            hold_q <= wb_data;
            dest_q <= proc_onehot(pend_proc);
            st_q   <= ST_REPLY;
          end
        end
        ST_REPLY: begin
          if (msg_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_INV:   msg_kind = MSG_INVAL;
      ST_FETCH: msg_kind = pend_write ? MSG_FETCH_INV : MSG_FETCH;
      default:  msg_kind = MSG_REPLY;
    endcase
  end

  assign msg_valid = (st_q == ST_INV) || (st_q == ST_FETCH) || (st_q == ST_REPLY);
  assign msg_dest  = dest_q;
  assign msg_addr  = pend_addr;
  assign msg_data  = (st_q == ST_REPLY) ? hold_q : '0;

endmodule

// File: rtl/home_dir_ctrl_chk.sv
module home_dir_ctrl_chk #(
  parameter int NPROC = 4,
  parameter int DW    = 32,
  parameter int PW    = 2,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             wb_ready,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [1:0]       msg_kind,
  input logic [NPROC-1:0] msg_dest,
  input logic [AW-1:0]    msg_addr,
  input logic [DW-1:0]    msg_data,
  input logic [PW-1:0]    pend_proc,
  input logic             in_wait,
  input logic             ev_fetch_done
);

  p_msg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_dest)
                                && $stable(msg_addr) && $stable(msg_data));

  p_serial_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);

  p_wait_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> wb_ready && !req_ready && !msg_valid);

  p_reply_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == 2'd0 |-> $countones(msg_dest) == 1 && msg_dest[pend_proc]);

  p_inval_others_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == 2'd1 |-> msg_dest != '0 && !msg_dest[pend_proc] && msg_data == '0);

  p_inval_then_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == 2'd1 && msg_ready |=> msg_valid && msg_kind == 2'd0);

  p_fetch_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind[1] |-> $countones(msg_dest) == 1 && msg_data == '0);

  p_fetch_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind[1] && msg_ready |=> in_wait);

  p_answer_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_done |=> msg_valid && msg_kind == 2'd0);

endmodule

bind home_dir_ctrl home_dir_ctrl_chk #(
  .NPROC(NPROC), .DW(DW), .PW(PW), .AW(AW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .wb_ready      (wb_ready),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_kind      (msg_kind),
  .msg_dest      (msg_dest),
  .msg_addr      (msg_addr),
  .msg_data      (msg_data),
  .pend_proc     (pend_proc),
  .in_wait       (in_wait),
  .ev_fetch_done (ev_fetch_done)
);

// File: tb/home_dir_ctrl_test.sv
`timescale 1ns/1ps
module home_dir_ctrl_test;

  localparam logic [1:0] K_REP = 2'd0, K_INV = 2'd1, K_FET = 2'd2, K_FIN = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_proc = '0;
  logic [2:0]  req_addr = '0;
  logic        req_ready;
  logic        wb_valid = 1'b0;
  logic [1:0]  wb_proc = '0;
  logic [2:0]  wb_addr = '0;
  logic [31:0] wb_data = '0;
  logic        wb_ready;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [1:0]  msg_kind;
  logic [3:0]  msg_dest;
  logic [2:0]  msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  home_dir_ctrl #(.NPROC(4), .NBLK(8), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_proc(req_proc), .req_addr(req_addr),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_proc(wb_proc),
    .wb_addr(wb_addr), .wb_data(wb_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_dest(msg_dest), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [31:0] seed(input int i);
    return 32'hC0DE0000 + i;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_req(input bit wr, input logic [1:0] p, input logic [2:0] a);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_proc = p; req_addr = a;
    #1;
    while (!req_ready && n < 100) begin @(negedge clk); #1; n++; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic send_wb(input logic [1:0] p, input logic [2:0] a, input logic [31:0] d);
    int n = 0;
    @(negedge clk);
    wb_valid = 1'b1; wb_proc = p; wb_addr = a; wb_data = d;
    #1;
    while (!wb_ready && n < 100) begin @(negedge clk); #1; n++; end
    @(posedge clk); #1;
    wb_valid = 1'b0;
  endtask

  task automatic expect_msg(input logic [1:0] k, input logic [3:0] d, input logic [2:0] a,
                            input logic [31:0] dat, input int stall, input string req);
    int n = 0;
    bit steady = 1;
    logic [40:0] snap;
    @(negedge clk); #1;
    while (!msg_valid && n < 100) begin @(negedge clk); #1; n++; end
    snap = {msg_kind, msg_dest, msg_addr, msg_data};
    for (int i = 0; i < stall; i++) begin
      @(negedge clk); #1;
      if (!msg_valid || {msg_kind, msg_dest, msg_addr, msg_data} !== snap) steady = 0;
    end
    if (stall > 0)
      check(steady, "R12", "message held while stalled",
            64'({msg_valid, msg_kind, msg_dest, msg_addr, msg_data}), 64'({1'b1, snap}));
    check(msg_valid && snap === {k, d, a, dat}, req, "message kind/dest/addr/data",
          64'({msg_valid, snap}), 64'({1'b1, k, d, a, dat}));
    msg_ready = 1'b1;
    @(posedge clk); #1;
    msg_ready = 1'b0;
  endtask

  task automatic expect_quiet(input int cyc, input string req);
    bit quiet = 1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); #1;
      if (msg_valid) quiet = 0;
    end
    check(quiet, req, "no message offered", 64'(!quiet), 64'd0);
  endtask

  // R1: reset state
  task automatic t_reset;
    @(negedge clk); #1;
    check(!msg_valid && req_ready && wb_ready, "R1", "idle after reset",
          64'({msg_valid, req_ready, wb_ready}), 64'({1'b0, 1'b1, 1'b1}));
  endtask

  // R2, R4, R5: readers then writer with other sharers
  task automatic t_share_then_write;
    send_req(1'b0, 2'd1, 3'd2);
    expect_msg(K_REP, 4'b0010, 3'd2, seed(2), 0, "R2");
    send_req(1'b0, 2'd3, 3'd2);
    expect_msg(K_REP, 4'b1000, 3'd2, seed(2), 2, "R4");
    send_req(1'b1, 2'd0, 3'd2);
    @(negedge clk); #1;
    check(!req_ready, "R11", "request held off during invalidate", 64'(req_ready), 64'd0);
    expect_msg(K_INV, 4'b1010, 3'd2, 32'd0, 1, "R5");
    expect_msg(K_REP, 4'b0001, 3'd2, seed(2), 0, "R5");
  endtask

  // R7: read from exclusive owner, then write with one other sharer
  task automatic t_fetch_read;
    send_req(1'b0, 2'd2, 3'd2);
    expect_msg(K_FET, 4'b0001, 3'd2, 32'd0, 0, "R7");
    @(negedge clk); #1;
    check(!req_ready && wb_ready, "R11", "waiting: requests closed, write-backs open",
          64'({req_ready, wb_ready}), 64'({1'b0, 1'b1}));
    send_wb(2'd0, 3'd2, 32'h1111_2222);
    expect_msg(K_REP, 4'b0100, 3'd2, 32'h1111_2222, 0, "R7");
    // block now Shared by P0 and P2; memory must hold the fetched word
    send_req(1'b1, 2'd2, 3'd2);
    expect_msg(K_INV, 4'b0001, 3'd2, 32'd0, 0, "R7");
    expect_msg(K_REP, 4'b0100, 3'd2, 32'h1111_2222, 0, "R7");
  endtask

  // R8: write miss on exclusive block
  task automatic t_fetch_write;
    send_req(1'b1, 2'd1, 3'd2);
    expect_msg(K_FIN, 4'b0100, 3'd2, 32'd0, 2, "R8");
    send_wb(2'd2, 3'd2, 32'h3333_0000);
    expect_msg(K_REP, 4'b0010, 3'd2, 32'h3333_0000, 0, "R8");
  endtask

  // R9, R6: eviction by owner, then sole-sharer upgrade
  task automatic t_evict_and_upgrade;
    send_wb(2'd1, 3'd2, 32'h4444_0000);
    expect_quiet(3, "R9");
    send_req(1'b0, 2'd3, 3'd2);
    expect_msg(K_REP, 4'b1000, 3'd2, 32'h4444_0000, 0, "R9");
    send_req(1'b1, 2'd3, 3'd2);
    expect_msg(K_REP, 4'b1000, 3'd2, 32'h4444_0000, 0, "R6");
  endtask

  // R10: foreign and stale write-backs discarded
  task automatic t_ignored_wb;
    send_wb(2'd0, 3'd2, 32'hDEAD_0002);
    send_wb(2'd3, 3'd5, 32'hDEAD_0005);
    expect_quiet(2, "R10");
    send_req(1'b0, 2'd0, 3'd5);
    expect_msg(K_REP, 4'b0001, 3'd5, seed(5), 0, "R10");
    send_req(1'b0, 2'd0, 3'd2);
    expect_msg(K_FET, 4'b1000, 3'd2, 32'd0, 0, "R10");
    send_wb(2'd3, 3'd2, 32'h5555_0000);
    expect_msg(K_REP, 4'b0001, 3'd2, 32'h5555_0000, 0, "R10");
  endtask

  // R3: write miss to an uncached block makes requester owner
  task automatic t_uncached_write;
    send_req(1'b1, 2'd1, 3'd7);
    expect_msg(K_REP, 4'b0010, 3'd7, seed(7), 0, "R3");
    send_req(1'b0, 2'd2, 3'd7);
    expect_msg(K_FET, 4'b0010, 3'd7, 32'd0, 0, "R3");
    send_wb(2'd1, 3'd7, 32'h7777_0000);
    expect_msg(K_REP, 4'b0100, 3'd7, 32'h7777_0000, 0, "R3");
  endtask

  // R11: unrelated eviction while a fetch answer is awaited
  task automatic t_evict_during_wait;
    send_req(1'b1, 2'd3, 3'd6);
    expect_msg(K_REP, 4'b1000, 3'd6, seed(6), 0, "R11");
    send_req(1'b1, 2'd0, 3'd4);
    expect_msg(K_REP, 4'b0001, 3'd4, seed(4), 0, "R11");
    send_req(1'b0, 2'd1, 3'd4);
    expect_msg(K_FET, 4'b0001, 3'd4, 32'd0, 0, "R11");
    send_wb(2'd3, 3'd6, 32'h6666_0000);
    @(negedge clk); #1;
    check(!msg_valid && !req_ready, "R11", "eviction does not end the wait",
          64'({msg_valid, req_ready}), 64'd0);
    send_wb(2'd0, 3'd4, 32'h4040_0000);
    expect_msg(K_REP, 4'b0010, 3'd4, 32'h4040_0000, 0, "R11");
    send_req(1'b0, 2'd2, 3'd6);
    expect_msg(K_REP, 4'b0100, 3'd6, 32'h6666_0000, 0, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_share_then_write();
    t_fetch_read();
    t_fetch_write();
    t_evict_and_upgrade();
    t_ignored_wb();
    t_uncached_write();
    t_evict_during_wait();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule